// File: doc/BRIEF.md
# Byte/Word Memory Bank Access Sequencer

This block sits between a requester and a 16-bit memory. The memory is split into two byte-wide banks: the even bank on the low data lane and the odd bank on the high data lane. The requester asks for a byte or a word at any 20-bit address, for either a read or a write. The block turns each request into one or two bus cycles. In each cycle it sets address bit 0 and an active-low high-bank enable, places write data on the correct lane and collects read bytes from the correct lane.

A word at an odd address spans both banks at two different word rows, so it cannot be moved in one cycle. The sequencer splits it. The first cycle moves the low byte through the odd bank at the requested address. The second cycle moves the high byte through the even bank at the next address. The two read bytes are joined into one result word. Every bus cycle waits for the memory's ready input. A one-clock done pulse ends the request, and any request that arrives while the block is busy is ignored.

Top module: `bank_seq`

## Requirements
- R1: A byte access at an even address runs one bus cycle with bus_addr equal to the request address (bit 0 = 0) and bus_bhe_n = 1; write data sits on bus_wdata[7:0] with the upper lane 0.
- R2: A byte access at an odd address runs one bus cycle with bus_addr equal to the request address (bit 0 = 1) and bus_bhe_n = 0; write data sits on bus_wdata[15:8] with the lower lane 0.
- R3: A word access at an even address runs exactly one bus cycle with bus_addr bit 0 = 0, bus_bhe_n = 0 and all 16 write bits in place.
- R4: A word access at an odd address runs exactly two bus cycles. The first uses the request address with bus_bhe_n = 0. The second uses the request address plus one, modulo 2^20, with bit 0 = 0 and bus_bhe_n = 1.
- R5: A bus cycle ends only on a clock edge where mem_ready = 1. While mem_ready = 0, bus_cyc stays 1 and bus_addr, bus_bhe_n and bus_wdata hold their values.
- R6: rd_data after a read is as follows. For a byte read it is {8'h00, byte from the bank that the address selects}. For an even word it is mem_rdata. For an odd word, the high lane of the first cycle becomes bits 7:0 and the low lane of the second cycle becomes bits 15:8.
- R7: For an odd-address word write, the first cycle carries req_wdata[7:0] on the upper lane and the second cycle carries req_wdata[15:8] on the lower lane, with the unused lane 0 in both.
- R8: done is high for exactly one clock, on the cycle after the edge that completed the final bus cycle, and rd_data is valid in that cycle.
- R9: req_valid is accepted only when the block is idle, which includes the cycle in which done is high. Requests raised while a bus cycle is pending cause no extra bus cycle and do not change the request in flight.
- R10: While rst_n = 0, bus_cyc = 0, bus_we = 0, bus_bhe_n = 1, bus_addr = 0, done = 0 and rd_data = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address of the request |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| mem_ready | input | 1 | Memory ends the current bus cycle |
| mem_rdata | input | 16 | Read data from both banks |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Bus address including bit 0 |
| bus_bhe_n | output | 1 | High (odd) bank enable, active low |
| bus_wdata | output | 16 | Lane-steered write data |
| rd_data | output | 16 | Assembled read result |
| done | output | 1 | One-clock completion pulse |

## Verification
Two events can land on the same clock: the done pulse that ends one request and the acceptance of the next one. Requests also keep arriving while a bus cycle is still pending. The bench issues every new request in the cycle where done is high and holds random requests on the inputs during busy cycles. It then checks that the next access begins at once, that the pulse from the previous access has dropped, and that a log of every completed bus cycle contains only the cycles of the request in flight. The memory model inserts random wait states and drives junk on mem_rdata outside ready cycles, so a read byte taken on the wrong edge shows up as a wrong result.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import bank_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mem_ready,
  output logic              cyc,
  output logic              phase2,
  output logic              lat_write,
  output logic              lat_word,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              beat_ok,
  output logic              final_beat,
  output logic              done
);

  seq_state_e state;

  // named events for the assertions
  logic accept;
  logic split;

  assign accept     = (state == ST_IDLE) && req_valid;
  assign split      = lat_word && lat_addr[0];
  assign cyc        = (state != ST_IDLE);
  assign phase2     = (state == ST_SECOND);
  assign beat_ok    = cyc && mem_ready;
  assign final_beat = beat_ok && (phase2 || !split);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_write <= 1'b0;
      lat_word  <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= final_beat;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            lat_write <= req_write;
            lat_word  <= req_word;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            state     <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (beat_ok) state <= split ? ST_SECOND : ST_IDLE;
        end
        ST_SECOND: begin
          if (beat_ok) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a request seen while busy leaves the captured request alone
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && req_valid) |=> ($stable(lat_addr) && $stable(lat_word)
                            && $stable(lat_write) && $stable(lat_wdata)));

  // R8: completion is a single-clock pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion only follows a ready edge during a bus cycle
  p_done_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cyc && mem_ready));

  // R4: a finished first half of an odd word is followed by a second cycle
  p_split_continues_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !phase2 && lat_word && lat_addr[0]) |=> (cyc && phase2 && !done));

  // R3: any other first cycle ends the request
  p_single_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !phase2 && !(lat_word && lat_addr[0])) |=> (done && !cyc));

endmodule

// File: rtl/bank_seq_lanes.sv
module bank_seq_lanes #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc,
  input  logic                phase2,
  input  logic                lat_write,
  input  logic                lat_word,
  input  logic [ADDR_W-1:0]   lat_addr,
  input  logic [2*LANE_W-1:0] lat_wdata,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_bhe_n,
  output logic [2*LANE_W-1:0] bus_wdata
);

  localparam int DATA_W = 2 * LANE_W;

  // address of the current bus cycle; the second half of a split word
  // moves to the following byte address
  function automatic logic [ADDR_W-1:0] cycle_addr(
    input logic [ADDR_W-1:0] base, input logic second);
    return second ? (base + ADDR_W'(1)) : base;
  endfunction

  // high bank is disabled on the second half and on even byte accesses
  function automatic logic hi_disable(
    input logic word, input logic a0, input logic second);
    return second || (!word && !a0);
  endfunction

  // place write bytes on the lane of the bank being used
  function automatic logic [DATA_W-1:0] steer(
    input logic word, input logic a0, input logic second,
    input logic [DATA_W-1:0] wd);
    if (second)       return {{LANE_W{1'b0}}, wd[DATA_W-1:LANE_W]};
    if (word && !a0)  return wd;
    if (a0)           return {wd[LANE_W-1:0], {LANE_W{1'b0}}};
    return {{LANE_W{1'b0}}, wd[LANE_W-1:0]};
  endfunction

  always_comb begin
    if (cyc) begin
      bus_we    = lat_write;
      bus_addr  = cycle_addr(lat_addr, phase2);
      bus_bhe_n = hi_disable(lat_word, lat_addr[0], phase2);
      bus_wdata = lat_write ? steer(lat_word, lat_addr[0], phase2, lat_wdata)
                            : '0;
    end else begin
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_bhe_n = 1'b1;
      bus_wdata = '0;
    end
  end

  // R1: even byte keeps the high bank off
  p_even_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !lat_word && !bus_addr[0]) |-> bus_bhe_n);

  // R2: odd byte turns the high bank on
  p_odd_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !lat_word && bus_addr[0]) |-> !bus_bhe_n);

  // R3: aligned word uses both banks at an even address
  p_even_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && lat_word && !lat_addr[0]) |-> (!bus_bhe_n && !bus_addr[0]));

  // R4: second half is an even-bank cycle at the next address
  p_second_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase2) |-> (bus_bhe_n && !bus_addr[0]
                       && bus_addr == $past(bus_addr) + ADDR_W'(1)));

  // R7: an odd-address write cycle carries the request's low byte up high
  p_odd_write_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && bus_we && bus_addr[0])
      |-> (bus_wdata[DATA_W-1:LANE_W] == lat_wdata[LANE_W-1:0]
           && bus_wdata[LANE_W-1:0] == '0));

endmodule

// File: rtl/bank_seq_merge.sv
module bank_seq_merge #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat_ok,
  input  logic                final_beat,
  input  logic                phase2,
  input  logic                lat_write,
  input  logic                lat_word,
  input  logic                lat_a0,
  input  logic [2*LANE_W-1:0] mem_rdata,
  output logic [2*LANE_W-1:0] rd_data
);

  localparam int DATA_W = 2 * LANE_W;

  logic [LANE_W-1:0] lo_hold;
  logic              rd_beat;

  assign rd_beat = beat_ok && !lat_write;

  // byte from the bank selected by address bit 0
  function automatic logic [LANE_W-1:0] pick_lane(
    input logic [DATA_W-1:0] d, input logic a0);
    return a0 ? d[DATA_W-1:LANE_W] : d[LANE_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] assemble(
    input logic word, input logic a0, input logic second,
    input logic [LANE_W-1:0] held, input logic [DATA_W-1:0] d);
    if (second) return {d[LANE_W-1:0], held};
    if (word)   return d;
    return {{LANE_W{1'b0}}, pick_lane(d, a0)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_hold <= '0;
      rd_data <= '0;
    end else if (rd_beat) begin
      if (!final_beat) lo_hold <= pick_lane(mem_rdata, 1'b1);
      else             rd_data <= assemble(lat_word, lat_a0, phase2, lo_hold, mem_rdata);
    end
  end

  // R6: split read joins the held odd-bank byte under the even-bank byte
  p_split_join_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && final_beat && phase2)
      |=> (rd_data[LANE_W-1:0] == $past(lo_hold)
           && rd_data[DATA_W-1:LANE_W] == $past(mem_rdata[LANE_W-1:0])));

  // R6: byte reads are zero-extended
  p_byte_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && final_beat && !lat_word) |=> (rd_data[DATA_W-1:LANE_W] == '0));

endmodule

// File: rtl/bank_seq.sv
module bank_seq #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic                mem_ready,
  input  logic [2*LANE_W-1:0] mem_rdata,
  output logic                bus_cyc,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_bhe_n,
  output logic [2*LANE_W-1:0] bus_wdata,
  output logic [2*LANE_W-1:0] rd_data,
  output logic                done
);

  localparam int DATA_W = 2 * LANE_W;

  logic              phase2;
  logic              lat_write;
  logic              lat_word;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              beat_ok;
  logic              final_beat;

  bank_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_word   (req_word),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_ready  (mem_ready),
    .cyc        (bus_cyc),
    .phase2     (phase2),
    .lat_write  (lat_write),
    .lat_word   (lat_word),
    .lat_addr   (lat_addr),
    .lat_wdata  (lat_wdata),
    .beat_ok    (beat_ok),
    .final_beat (final_beat),
    .done       (done)
  );

  bank_seq_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc       (bus_cyc),
    .phase2    (phase2),
    .lat_write (lat_write),
    .lat_word  (lat_word),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_bhe_n (bus_bhe_n),
    .bus_wdata (bus_wdata)
  );

  bank_seq_merge #(.LANE_W(LANE_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_ok    (beat_ok),
    .final_beat (final_beat),
    .phase2     (phase2),
    .lat_write  (lat_write),
    .lat_word   (lat_word),
    .lat_a0     (lat_addr[0]),
    .mem_rdata  (mem_rdata),
    .rd_data    (rd_data)
  );

  // R5: a cycle without ready keeps the bus frozen
  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !mem_ready)
      |=> (bus_cyc && $stable(bus_addr) && $stable(bus_bhe_n)
           && $stable(bus_wdata) && $stable(bus_we)));

  // R10: reset values at the ports
  always_comb begin
    if (!rst_n) begin
      p_reset_idle_r10: assert (!bus_cyc && !done && bus_bhe_n && !bus_we);
    end
  end

endmodule

// File: tb/bank_seq_test.sv
module bank_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        mem_ready;
  logic [15:0] mem_rdata;
  logic        bus_cyc, bus_we, bus_bhe_n, done;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, rd_data;

  always #4 clk = ~clk;

  bank_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .bus_cyc(bus_cyc),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .done(done)
  );

  int nvec = 0;
  int nbad = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  logic [7:0] dev_mem [256];
  logic [7:0] ref_mem [256];

  // log of completed bus cycles
  int          log_n;
  logic [19:0] log_addr [4];
  logic        log_bhe  [4];
  logic        log_we   [4];
  logic [15:0] log_wd   [4];
  int          log_cnt  [4];

  // responder state
  bit          in_beat = 0;
  int          waits   = 0;
  logic [19:0] snap_addr;
  logic        snap_bhe;
  logic [15:0] snap_wd;

  always @(posedge clk) cyc_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory with random wait states; junk on the read lanes outside ready
  always @(negedge clk) begin
    if (rst_n && bus_cyc) begin
      if (!in_beat) begin
        in_beat   = 1;
        snap_addr = bus_addr;
        snap_bhe  = bus_bhe_n;
        snap_wd   = bus_wdata;
        waits     = $urandom % 4;
      end else begin
        chk(bus_addr == snap_addr && bus_bhe_n == snap_bhe && bus_wdata == snap_wd,
            "R5 bus held during wait", {bus_addr, 12'h0}, {snap_addr, 12'h0});
      end
      if (waits > 0) begin
        waits--;
        mem_ready = 1'b0;
        mem_rdata = 16'($urandom);
      end else begin
        mem_ready = 1'b1;
        in_beat   = 0;
        mem_rdata = {dev_mem[{bus_addr[7:1], 1'b1}], dev_mem[{bus_addr[7:1], 1'b0}]};
        if (bus_we) begin
          if (!bus_addr[0]) dev_mem[{bus_addr[7:1], 1'b0}] = bus_wdata[7:0];
          if (!bus_bhe_n)   dev_mem[{bus_addr[7:1], 1'b1}] = bus_wdata[15:8];
        end
        if (log_n < 4) begin
          log_addr[log_n] = bus_addr;
          log_bhe[log_n]  = bus_bhe_n;
          log_we[log_n]   = bus_we;
          log_wd[log_n]   = bus_wdata;
          log_cnt[log_n]  = cyc_cnt;
        end
        log_n++;
      end
    end else begin
      mem_ready = 1'b0;
      in_beat   = 0;
      mem_rdata = 16'($urandom);
    end
  end

  // expected bus cycle idx of an access, written per case
  function automatic void exp_cycle(input bit wr, input bit wd, input logic [19:0] a,
                                    input logic [15:0] d, input int idx,
                                    output logic [19:0] ea, output logic eb,
                                    output logic [15:0] ew);
    if (!wd) begin
      ea = a; eb = ~a[0];
      ew = a[0] ? {d[7:0], 8'h00} : {8'h00, d[7:0]};
    end else if (!a[0]) begin
      ea = a; eb = 1'b0; ew = d;
    end else if (idx == 0) begin
      ea = a; eb = 1'b0; ew = {d[7:0], 8'h00};
    end else begin
      ea = 20'(a + 20'd1); eb = 1'b1; ew = {8'h00, d[15:8]};
    end
    if (!wr) ew = 16'h0000;
  endfunction

  function automatic string tag_for(input bit wd, input logic [19:0] a);
    if (!wd) return a[0] ? "R2" : "R1";
    return a[0] ? "R4" : "R3";
  endfunction

  // called right after a negedge; returns at the negedge where done is high
  task automatic access(input bit wr, input bit wd, input logic [19:0] a,
                        input logic [15:0] d, input bit noise);
    logic [15:0] exp_rd;
    logic [19:0] a1;
    int          exp_n;
    int          t;
    string       tg;
    a1     = 20'(a + 20'd1);
    exp_n  = (wd && a[0]) ? 2 : 1;
    tg     = tag_for(wd, a);
    exp_rd = wd ? {ref_mem[a1[7:0]], ref_mem[a[7:0]]} : {8'h00, ref_mem[a[7:0]]};
    log_n  = 0;
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", {31'b0, done}, 32'h0);
    chk(bus_cyc == 1'b1, "R9 accepted when idle or on done", {31'b0, bus_cyc}, 32'h1);
    t = 0;
    while (!done && t < 64) begin
      req_valid = noise ? 1'($urandom) : 1'b0;
      req_write = 1'($urandom); req_word = 1'($urandom);
      req_addr  = 20'($urandom); req_wdata = 16'($urandom);
      @(negedge clk);
      t++;
    end
    req_valid = 1'b0;
    chk(done == 1'b1, "R8 done arrives", {31'b0, done}, 32'h1);
    chk(log_n == exp_n, noise ? "R9 no extra bus cycles" : tg, log_n, exp_n);
    if (log_n == exp_n) begin
      chk(log_cnt[exp_n-1] + 1 == cyc_cnt, "R8 done one clock after final ready",
          cyc_cnt, log_cnt[exp_n-1] + 1);
      for (int i = 0; i < exp_n; i++) begin
        logic [19:0] ea; logic eb; logic [15:0] ew;
        exp_cycle(wr, wd, a, d, i, ea, eb, ew);
        chk(log_addr[i] == ea && log_bhe[i] == eb && log_we[i] == wr, tg,
            {log_addr[i], 3'b0, log_bhe[i], 3'b0, log_we[i], 4'h0},
            {ea, 3'b0, eb, 3'b0, wr, 4'h0});
        if (wr) chk(log_wd[i] == ew, (wd && a[0]) ? "R7 split write lanes" : tg,
                    log_wd[i], ew);
      end
    end
    if (wr) begin
      ref_mem[a[7:0]] = d[7:0];
      if (wd) ref_mem[a1[7:0]] = d[15:8];
    end else begin
      chk(rd_data == exp_rd, "R6 assembled read", rd_data, exp_rd);
    end
  endtask

  initial begin
    void'($urandom(32'h0BA5E));
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = 8'($urandom);
      ref_mem[i] = dev_mem[i];
    end
    log_n = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!bus_cyc && !done && bus_bhe_n && !bus_we && bus_addr == 20'h0 && rd_data == 16'h0,
        "R10 reset state", {bus_cyc, done, bus_bhe_n, bus_we, bus_addr, rd_data[7:0]},
        {4'b0010, 20'h0, 8'h0});
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    access(1, 0, 20'h00010, 16'h00A5, 0);  // R1 even byte write
    access(0, 0, 20'h00010, 16'h0,    0);  // R1 read back
    access(1, 0, 20'h00013, 16'h003C, 0);  // R2 odd byte write
    access(0, 0, 20'h00013, 16'h0,    1);  // R2 read, noise R9
    access(1, 1, 20'h00020, 16'hBEEF, 0);  // R3 even word
    access(0, 1, 20'h00020, 16'h0,    0);
    access(1, 1, 20'h00031, 16'h1234, 1);  // R4 R7 odd word write with noise
    access(0, 1, 20'h00031, 16'h0,    1);  // R4 R6 odd word read
    access(1, 1, 20'hFFFFF, 16'hC0DE, 0);  // R4 wrap to address 0
    access(0, 1, 20'hFFFFF, 16'h0,    0);
    access(0, 0, 20'h00000, 16'h0,    0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      access(1'($urandom), 1'($urandom), 20'($urandom), 16'($urandom), 1'($urandom));
    end
    // final readback of every word slot
    for (int k = 0; k < 256; k += 2) access(0, 1, 20'(k), 16'h0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nbad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=done", cyc_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule